// File: doc/BRIEF.md
# Register-Write Command Stream Executor

This block reads a list of 64-bit commands from a memory read port and turns them into writes on a write-only register bus. Software sets a head byte address and then writes a tail byte address. That tail write starts the engine. The engine fetches commands in order from the head and stops when its fetch pointer reaches the tail at a command boundary.

Each command is two 32-bit words. The supported commands are:
- single register writes with per-byte enables;
- burst writes that send a counted payload to one register;
- no-operations;
- a completion interrupt;
- five kinds of wait.

The engine does not time waits itself. It hands each wait to an external timing unit over a request/done handshake and stalls until that unit reports done.

A halt input or a dropped enable stops the engine at once. Sticky status flags record completion interrupts, illegal commands and rejected tail writes. Software clears each flag by writing a one to it.

Top module: `regwr_cmd_engine`

## Requirements
- R1: When the engine is idle, a pulse on `tail_wr_i` with `en_i` high, `halt_i` low and `tail_i[5:0]==0` starts it. On the next cycle `busy_o` is high and `cur_addr_o` equals `head_i`, which must be 8-byte aligned. `cur_addr_o` always reports the current fetch byte address.
- R2: A command is the 32-bit word at byte address A (the argument word) followed by the word at A+4 (the control word). Bits 31:24 of the control word hold the opcode. The memory port returns data one cycle after a read request.
- R3: Opcode 0x01 performs one register write. The register offset is control bits 19:0, the byte enables are control bits 23:20 (bit 20 enables data bits 7:0), and the data is the argument word.
- R4: Opcode 0x09 is a burst. The argument word is a count N, and N payload words follow the command. Each payload word is written to the offset in control bits 19:0 with all byte enables set. If N is odd, one pad word after the payload is skipped without being written. N=0 writes nothing.
- R5: Opcodes 0x02 to 0x06 are waits. `wait_req_o` stays high, with `wait_op_o` (the opcode), `wait_arg_o` (the argument word) and `wait_ext_o` (control bits 23:0) held steady, until `wait_done_i` is seen. No fetch and no register write happen while the wait is pending.
- R6: Opcode 0x00 does nothing except advance to the next command.
- R7: Opcode 0x07 raises `irq_o` for exactly one cycle and sets status bit 0.
- R8: At each command boundary the engine compares the fetch address with the latched tail. When they are equal it stops: `busy_o` falls and `cur_addr_o` equals the tail.
- R9: Opcode 0x0A and every opcode not listed above set status bit 1 and stop the engine. Nothing after that command is executed.
- R10: A tail write while busy, or a tail write with a value that is not 64-byte aligned, is ignored and sets status bit 2. A running program keeps its original tail.
- R11: When `halt_i` is high or `en_i` is low while the engine is busy, the engine is idle on the next cycle and issues no further register writes. With `en_i` low, a tail write starts nothing.
- R12: Writing a one to a bit of `status_clr_i` clears that status bit. A set in the same cycle takes priority over the clear.
- R13: The register bus is write-only. Memory reads happen only while the engine is busy, and every read address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Engine enable |
| halt_i | input | 1 | Stop execution |
| head_i | input | AW | Start byte address of the command list |
| tail_i | input | AW | End byte address, 64-byte aligned |
| tail_wr_i | input | 1 | Tail write strobe; starts the engine |
| status_clr_i | input | 3 | Write-one-to-clear for the status bits |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read byte address |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the request |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 20 | Register offset |
| reg_be_o | output | 4 | Byte enables |
| reg_wdata_o | output | 32 | Write data |
| wait_req_o | output | 1 | Wait request to the timing unit |
| wait_op_o | output | 8 | Opcode of the pending wait |
| wait_arg_o | output | 32 | Argument word of the wait |
| wait_ext_o | output | 24 | Control bits 23:0 of the wait |
| wait_done_i | input | 1 | Timing unit reports the wait is complete |
| busy_o | output | 1 | Engine is running |
| cur_addr_o | output | AW | Current fetch byte address |
| irq_o | output | 1 | One-cycle completion interrupt |
| status_o | output | 3 | Sticky flags: bit 0 interrupt, bit 1 illegal command, bit 2 rejected tail |

## Verification
The checks assume that the head address is 8-byte aligned, because the read-alignment property depends on it. They also assume that the wait unit answers only while a request is pending. The bench places every program at word indices that are multiples of 16, so every head and tail is 64-byte aligned. The exception is one deliberately misaligned tail, which is presented only while the engine is idle. The wait responder in the bench raises done for a single cycle after a fixed delay, and only while `wait_req_o` is high. Halt, enable and tail strobes are driven shortly after the falling edge, so each one is seen at exactly one rising edge.

// File: rtl/regwr_cmd_pkg.sv
package regwr_cmd_pkg;
  localparam logic [7:0] OP_NOP   = 8'h00;
  localparam logic [7:0] OP_WR    = 8'h01;
  localparam logic [7:0] OP_WUS   = 8'h02;
  localparam logic [7:0] OP_WLINE = 8'h03;
  localparam logic [7:0] OP_WVBL  = 8'h04;
  localparam logic [7:0] OP_WIN   = 8'h05;
  localparam logic [7:0] OP_WOUT  = 8'h06;
  localparam logic [7:0] OP_IRQ   = 8'h07;
  localparam logic [7:0] OP_IDX   = 8'h09;

  localparam int N_STS   = 3;
  localparam int STS_IRQ = 0;
  localparam int STS_BAD = 1;
  localparam int STS_TL  = 2;

  typedef enum logic [2:0] {
    C_NOP, C_WR, C_WAIT, C_IRQ, C_IDX, C_BAD
  } cmd_class_e;
endpackage

// File: rtl/regwr_cmd_decode.sv
module regwr_cmd_decode
  import regwr_cmd_pkg::*;
(
  input  logic [7:0] op_i,
  output cmd_class_e cls_o
);
  always_comb begin
    unique case (op_i)
      OP_NOP:                                   cls_o = C_NOP;
      OP_WR:                                    cls_o = C_WR;
      OP_WUS, OP_WLINE, OP_WVBL, OP_WIN, OP_WOUT: cls_o = C_WAIT;
      OP_IRQ:                                   cls_o = C_IRQ;
      OP_IDX:                                   cls_o = C_IDX;
      default:                                  cls_o = C_BAD; // poll and undefined
    endcase
  end
endmodule

// File: rtl/regwr_cmd_status.sv
module regwr_cmd_status #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         irq_i,
  output logic [N-1:0] sts_o,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_o <= '0;
      irq_o <= 1'b0;
    end else begin
      sts_o <= (sts_o & ~clr_i) | set_i; // set wins
      irq_o <= irq_i;
    end
  end
endmodule

// File: rtl/regwr_cmd_engine.sv
module regwr_cmd_engine
  import regwr_cmd_pkg::*;
#(
  parameter int AW       = 16,
  parameter int ALIGN_LG = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              halt_i,
  input  logic [AW-1:0]     head_i,
  input  logic [AW-1:0]     tail_i,
  input  logic              tail_wr_i,
  input  logic [N_STS-1:0]  status_clr_i,
  output logic              mem_rd_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              reg_we_o,
  output logic [19:0]       reg_addr_o,
  output logic [3:0]        reg_be_o,
  output logic [31:0]       reg_wdata_o,
  output logic              wait_req_o,
  output logic [7:0]        wait_op_o,
  output logic [31:0]       wait_arg_o,
  output logic [23:0]       wait_ext_o,
  input  logic              wait_done_i,
  output logic              busy_o,
  output logic [AW-1:0]     cur_addr_o,
  output logic              irq_o,
  output logic [N_STS-1:0]  status_o
);
  localparam logic [AW-1:0] WSTEP = AW'(4);
  localparam logic [AW-1:0] CSTEP = AW'(8);

  typedef enum logic [2:0] {
    S_IDLE, S_RD_LO, S_CAP_LO, S_CAP_HI, S_EXEC, S_WAIT, S_RD_DAT, S_CAP_DAT
  } st_e;

  st_e           st_q;
  logic [AW-1:0] ptr_q, tail_q;
  logic [31:0]   lo_q, hi_q, cnt_q;
  cmd_class_e    cls;
  logic          stop, tail_ok, start, at_end;
  logic          irq_set, bad_set, tail_err;

  regwr_cmd_decode u_dec (.op_i(hi_q[31:24]), .cls_o(cls));

  assign stop    = halt_i | ~en_i;
  assign tail_ok = (tail_i[ALIGN_LG-1:0] == '0);
  assign start   = (st_q == S_IDLE) & tail_wr_i & ~stop & tail_ok;
  assign at_end  = (ptr_q == tail_q);

  assign tail_err = tail_wr_i & ((st_q != S_IDLE) | ~tail_ok);
  assign irq_set  = ~stop & (st_q == S_EXEC) & (cls == C_IRQ);
  assign bad_set  = ~stop & (st_q == S_EXEC) & (cls == C_BAD);

  // memory side: control word read is overlapped with argument capture
  assign mem_rd_o   = ~stop & (((st_q == S_RD_LO) & ~at_end) |
                               (st_q == S_CAP_LO) | (st_q == S_RD_DAT));
  assign mem_addr_o = (st_q == S_CAP_LO) ? ptr_q + WSTEP : ptr_q;

  // register side
  assign reg_we_o    = ~stop & (((st_q == S_EXEC) & (cls == C_WR)) | (st_q == S_CAP_DAT));
  assign reg_addr_o  = hi_q[19:0];
  assign reg_be_o    = (st_q == S_CAP_DAT) ? 4'hF : hi_q[23:20];
  assign reg_wdata_o = (st_q == S_CAP_DAT) ? mem_rdata_i : lo_q;

  assign wait_req_o = ~stop & (st_q == S_WAIT);
  assign wait_op_o  = hi_q[31:24];
  assign wait_arg_o = lo_q;
  assign wait_ext_o = hi_q[23:0];

  assign busy_o     = (st_q != S_IDLE);
  assign cur_addr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      ptr_q  <= '0;
      tail_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      cnt_q  <= '0;
    end else if (stop && st_q != S_IDLE) begin
      st_q <= S_IDLE;
    end else begin
      unique case (st_q)
        S_IDLE: if (start) begin
          ptr_q  <= head_i;
          tail_q <= tail_i;
          st_q   <= S_RD_LO;
        end
        S_RD_LO:  st_q <= at_end ? S_IDLE : S_CAP_LO;
        S_CAP_LO: begin
          lo_q <= mem_rdata_i;
          st_q <= S_CAP_HI;
        end
        S_CAP_HI: begin
          hi_q  <= mem_rdata_i;
          ptr_q <= ptr_q + CSTEP;
          st_q  <= S_EXEC;
        end
        S_EXEC: begin
          unique case (cls)
            C_WAIT: st_q <= S_WAIT;
            C_BAD:  st_q <= S_IDLE;
            C_IDX: begin
              cnt_q <= lo_q;
              st_q  <= (lo_q == '0) ? S_RD_LO : S_RD_DAT;
            end
            default: st_q <= S_RD_LO;
          endcase
        end
        S_WAIT:   if (wait_done_i) st_q <= S_RD_LO;
        S_RD_DAT: st_q <= S_CAP_DAT;
        S_CAP_DAT: begin
          cnt_q <= cnt_q - 32'd1;
          if (cnt_q == 32'd1) begin
            ptr_q <= lo_q[0] ? ptr_q + CSTEP : ptr_q + WSTEP; // skip pad on odd count
            st_q  <= S_RD_LO;
          end else begin
            ptr_q <= ptr_q + WSTEP;
            st_q  <= S_RD_DAT;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  logic [N_STS-1:0] sts_set;
  always_comb begin
    sts_set          = '0;
    sts_set[STS_IRQ] = irq_set;
    sts_set[STS_BAD] = bad_set;
    sts_set[STS_TL]  = tail_err;
  end

  regwr_cmd_status #(.N(N_STS)) u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sts_set),
    .clr_i  (status_clr_i),
    .irq_i  (irq_set),
    .sts_o  (status_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/regwr_cmd_engine_chk.sv
module regwr_cmd_engine_chk
  import regwr_cmd_pkg::*;
#(
  parameter int AW       = 16,
  parameter int ALIGN_LG = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              halt_i,
  input logic [AW-1:0]     head_i,
  input logic [AW-1:0]     tail_i,
  input logic              tail_wr_i,
  input logic [N_STS-1:0]  status_clr_i,
  input logic              mem_rd_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic [31:0]       mem_rdata_i,
  input logic              reg_we_o,
  input logic [19:0]       reg_addr_o,
  input logic [3:0]        reg_be_o,
  input logic [31:0]       reg_wdata_o,
  input logic              wait_req_o,
  input logic [7:0]        wait_op_o,
  input logic [31:0]       wait_arg_o,
  input logic [23:0]       wait_ext_o,
  input logic              wait_done_i,
  input logic              busy_o,
  input logic [AW-1:0]     cur_addr_o,
  input logic              irq_o,
  input logic [N_STS-1:0]  status_o
);
  p_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail_wr_i && en_i && !halt_i && !busy_o && tail_i[ALIGN_LG-1:0] == '0)
      |=> (busy_o && cur_addr_o == $past(head_i)));

  p_wait_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_req_o && !wait_done_i && !halt_i && en_i)
      |=> (wait_req_o && $stable(wait_op_o) && $stable(wait_arg_o) && $stable(wait_ext_o)));

  p_wait_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_req_o |-> (!mem_rd_o && !reg_we_o));

  p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_o[STS_IRQ]);

  p_tail_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail_wr_i && busy_o) |=> status_o[STS_TL]);

  p_halt_stop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (halt_i || !en_i)) |=> !busy_o);

  p_we_busy_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> busy_o);

  p_rd_busy_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (busy_o && mem_addr_o[1:0] == 2'b00));
endmodule

bind regwr_cmd_engine regwr_cmd_engine_chk #(.AW(AW), .ALIGN_LG(ALIGN_LG)) u_chk (.*);

// File: tb/regwr_cmd_engine_tb_top.sv
module regwr_cmd_engine_tb_top;
  localparam int AW = 16;
  localparam int WDLY = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic en_i = 1'b1, halt_i = 1'b0, tail_wr_i = 1'b0, wait_done_i = 1'b0;
  logic [AW-1:0] head_i = '0, tail_i = '0;
  logic [2:0] status_clr_i = '0;
  logic mem_rd_o, reg_we_o, wait_req_o, busy_o, irq_o;
  logic [AW-1:0] mem_addr_o, cur_addr_o;
  logic [31:0] mem_rdata_i = '0, reg_wdata_o, wait_arg_o;
  logic [19:0] reg_addr_o;
  logic [3:0] reg_be_o;
  logic [7:0] wait_op_o;
  logic [23:0] wait_ext_o;
  logic [2:0] status_o;

  regwr_cmd_engine #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_i), .halt_i(halt_i),
    .head_i(head_i), .tail_i(tail_i), .tail_wr_i(tail_wr_i),
    .status_clr_i(status_clr_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_rdata_i(mem_rdata_i), .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o),
    .reg_be_o(reg_be_o), .reg_wdata_o(reg_wdata_o), .wait_req_o(wait_req_o),
    .wait_op_o(wait_op_o), .wait_arg_o(wait_arg_o), .wait_ext_o(wait_ext_o),
    .wait_done_i(wait_done_i), .busy_o(busy_o), .cur_addr_o(cur_addr_o),
    .irq_o(irq_o), .status_o(status_o)
  );

  int checks = 0, errors = 0;
  int irq_cnt = 0, wr_seen = 0, wait_seen = 0, stall_bad = 0, rd_idle_bad = 0, wcnt = 0;
  bit no_write_win = 0;
  logic [31:0] mem [0:511];
  logic [55:0] exp_wr[$];
  logic [63:0] exp_wait[$];
  int wp = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  // memory model: one-cycle read latency
  always @(posedge clk) if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[10:2]];

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // per-clock comparison against the program-built reference stream
  always @(negedge clk) if (rst_n) begin
    if (mem_rd_o && !busy_o) rd_idle_bad++;
    if (wait_req_o && (mem_rd_o || reg_we_o)) stall_bad++;
    if (irq_o) irq_cnt++;
    if (reg_we_o) begin
      wr_seen++;
      if (no_write_win) chk(0, "R11 write after halt", {12'h0, reg_addr_o, reg_be_o, reg_wdata_o}, 0);
      else if (exp_wr.size() == 0) chk(0, "R3/R4 unexpected write", {12'h0, reg_addr_o, reg_be_o, reg_wdata_o}, 0);
      else begin
        logic [55:0] e;
        e = exp_wr.pop_front();
        chk({reg_addr_o, reg_be_o, reg_wdata_o} == e, "R3/R4 write", {8'h0, reg_addr_o, reg_be_o, reg_wdata_o}, {8'h0, e});
      end
    end
  end

  // wait unit model
  always @(negedge clk) begin
    #1;
    if (wait_done_i) wait_done_i = 1'b0;
    else if (!wait_req_o) wcnt = 0;
    else begin
      wcnt++;
      if (wcnt == 1) begin
        logic [63:0] e;
        wait_seen++;
        e = (exp_wait.size() != 0) ? exp_wait.pop_front() : 64'hFFFF_FFFF_FFFF_FFFF;
        chk({wait_op_o, wait_ext_o, wait_arg_o} == e, "R5 wait fields", {wait_op_o, wait_ext_o, wait_arg_o}, e);
      end
      if (wcnt == WDLY) begin
        wait_done_i = 1'b1;
        wcnt = 0;
      end
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic put(input logic [31:0] lo, input logic [31:0] hi);
    mem[wp] = lo; mem[wp+1] = hi; wp += 2;
  endtask
  task automatic e_wr(input logic [19:0] off, input logic [3:0] be, input logic [31:0] d);
    put(d, {8'h01, be, off});
    exp_wr.push_back({off, be, d});
  endtask
  task automatic e_idx(input logic [19:0] off, input int n, input logic [31:0] base);
    put(n, {8'h09, 4'h0, off});
    for (int i = 0; i < n; i++) begin
      mem[wp] = base + i; wp++;
      exp_wr.push_back({off, 4'hF, base + 32'(i)});
    end
    if (n % 2 == 1) begin mem[wp] = 32'h0; wp++; end
  endtask
  task automatic e_wait(input logic [7:0] op, input logic [31:0] arg, input logic [23:0] ext);
    put(arg, {op, ext});
    exp_wait.push_back({op, ext, arg});
  endtask
  task automatic pad_end(output int tail);
    while (wp % 16 != 0) put(0, 0);
    tail = wp * 4;
  endtask

  task automatic launch(input int head, input int tail);
    head_i = AW'(head); tail_i = AW'(tail); tail_wr_i = 1'b1;
    tick();
    tail_wr_i = 1'b0;
  endtask
  task automatic finish_run();
    int n = 0;
    while (busy_o && n < 5000) begin tick(); n++; end
  endtask

  initial begin
    int t1, t2, t3, t4, t5, t6;
    for (int i = 0; i < 512; i++) mem[i] = 32'h0;
    repeat (3) tick();
    // reset state
    chk(busy_o == 0, "R8 reset busy", busy_o, 0);
    chk(irq_o == 0, "R7 reset irq", irq_o, 0);
    chk(status_o == 0, "R12 reset status", status_o, 0);
    chk(reg_we_o == 0 && mem_rd_o == 0, "R13 reset bus idle", {reg_we_o, mem_rd_o}, 0);
    rst_n = 1'b1;
    tick();

    // program 1: writes, nop (R6), bursts odd/even/zero, irq (R2 layout)
    wp = 0;
    e_wr(20'h00123, 4'hF, 32'hDEADBEEF);
    put(32'hFFFF_FFFF, 32'h0000_0000);
    e_wr(20'h0ABCD, 4'b0101, 32'h11223344);
    e_idx(20'h00200, 3, 32'hA000_0000);
    e_idx(20'h00300, 2, 32'hB000_0000);
    e_idx(20'h00400, 0, 32'h0);
    put(0, {8'h07, 24'h0});
    e_wr(20'hFFFFF, 4'b1000, 32'h55AA55AA);
    pad_end(t1);
    launch(0, t1);
    chk(busy_o == 1 && cur_addr_o == 0, "R1 start", {busy_o, cur_addr_o}, {1'b1, 16'h0});
    finish_run();
    chk(exp_wr.size() == 0, "R3/R4/R6 all writes seen", exp_wr.size(), 0);
    chk(irq_cnt == 1, "R7 single irq pulse", irq_cnt, 1);
    chk(status_o == 3'b001, "R7 status irq", status_o, 3'b001);
    chk(!busy_o && cur_addr_o == AW'(t1), "R8 stop at tail", {busy_o, cur_addr_o}, {1'b0, AW'(t1)});

    status_clr_i = 3'b111; tick(); status_clr_i = 3'b000;
    chk(status_o == 0, "R12 w1c clear", status_o, 0);

    // program 2: waits
    wp = 64;
    e_wait(8'h02, 32'd5, 24'h0);
    e_wait(8'h03, 32'd100, 24'h0);
    e_wait(8'h04, 32'd2, 24'h0);
    e_wait(8'h05, 32'h0000_0010, 24'h000020);
    e_wait(8'h06, 32'd7, 24'h0000A5);
    e_wr(20'h00010, 4'hF, 32'h1);
    pad_end(t2);
    launch(256, t2);
    finish_run();
    chk(wait_seen == 5 && exp_wait.size() == 0, "R5 wait count", wait_seen, 5);
    chk(stall_bad == 0, "R5 stall during wait", stall_bad, 0);
    chk(exp_wr.size() == 0, "R5 write after waits", exp_wr.size(), 0);

    // program 3: tail write while busy ignored
    wp = 128;
    for (int i = 0; i < 20; i++) put(0, 0);
    e_wr(20'h00020, 4'hF, 32'h7);
    pad_end(t3);
    launch(512, t3);
    repeat (3) tick();
    tail_i = AW'(64); tail_wr_i = 1'b1; tick(); tail_wr_i = 1'b0; tick();
    chk(status_o[2] == 1, "R10 tail while busy flag", status_o, 3'b100);
    finish_run();
    chk(cur_addr_o == AW'(t3) && exp_wr.size() == 0, "R10 original tail kept", cur_addr_o, AW'(t3));

    status_clr_i = 3'b111; tick(); status_clr_i = 3'b000;
    // misaligned tail
    launch(0, 32'h104);
    chk(!busy_o && status_o[2], "R10 misaligned tail", {busy_o, status_o}, {1'b0, 3'b100});
    status_clr_i = 3'b111; tick(); status_clr_i = 3'b000;

    // program 4: poll opcode stops engine
    wp = 192;
    e_wr(20'h00030, 4'hF, 32'h1);
    put(0, {8'h0A, 24'h0});
    put(32'h2, {8'h01, 4'hF, 20'h00031});
    pad_end(t4);
    launch(768, t4);
    finish_run();
    chk(status_o == 3'b010 && exp_wr.size() == 0, "R9 poll illegal", status_o, 3'b010);
    chk(cur_addr_o != AW'(t4), "R9 stopped early", cur_addr_o, AW'(t4));
    status_clr_i = 3'b111; tick(); status_clr_i = 3'b000;

    // program 5: undefined opcode
    wp = 208;
    put(0, {8'h0F, 24'h0});
    put(32'h3, {8'h01, 4'hF, 20'h00032});
    pad_end(t5);
    launch(832, t5);
    finish_run();
    chk(status_o == 3'b010, "R9 undefined opcode", status_o, 3'b010);
    status_clr_i = 3'b111; tick(); status_clr_i = 3'b000;

    // program 6: halt mid-run
    wp = 256;
    for (int i = 0; i < 8; i++) e_wr(20'h00100 + 20'(i), 4'hF, 32'hC0 + 32'(i));
    pad_end(t6);
    wr_seen = 0;
    launch(1024, t6);
    while (wr_seen < 2) tick();
    halt_i = 1'b1; no_write_win = 1'b1;
    tick();
    halt_i = 1'b0;
    chk(!busy_o, "R11 halt stops", busy_o, 0);
    repeat (30) tick();
    chk(!busy_o, "R11 stays idle", busy_o, 0);
    no_write_win = 1'b0;
    exp_wr.delete();

    // enable low: tail write starts nothing
    en_i = 1'b0;
    launch(1024, t6);
    chk(!busy_o, "R11 disabled no start", busy_o, 0);
    en_i = 1'b1;
    tick();

    chk(rd_idle_bad == 0, "R13 reads only while busy", rd_idle_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule